// File: doc/BRIEF.md
# Tiled Depth Buffer Address Translator

This block turns a pixel coordinate into the byte address of that pixel's depth word. The depth buffer is either a plain row-major surface or a tiled surface. In a tiled surface the low bits of x and y are permuted and partly XOR-folded together with a block index, so that nearby pixels fall into the same memory page. A rasteriser or a depth-test unit presents one request per cycle. Each request carries the pixel coordinate, the window origin, the surface pitch in pixels, the depth word size (16 or 32 bits), a linear/tiled flag and, for 32-bit tiled surfaces, a choice between 8-pixel and 16-pixel tile blocks.

The translation is a single registered stage. A request accepted on one clock edge shows up on `out_addr` with `out_valid` after that edge. A new request can be accepted on every edge. The pitch must be a multiple of the block width of the mode in use; other pitches give undefined addresses.

Top module: `tzaddr_translator`

## Requirements
- R1: The coordinate used for addressing is the absolute position ax = in_x + in_org_x and ay = in_y + in_org_y, computed without wrap-around (13-bit sums).
- R2: With in_linear = 1 and in_fmt = 1 (32-bit words), the address is 4 × (ax + ay × in_pitch).
- R3: With in_linear = 1 and in_fmt = 0 (16-bit words), the address is 2 × (ax + ay × in_pitch).
- R4: In 32-bit tiled mode the block index is B = (ay/s) × (in_pitch/s) + ax/s, where s = 8 when in_tile_wide = 0 and s = 16 when in_tile_wide = 1.
- R5: In 32-bit tiled mode the address is built as follows, and any bits above 31 are dropped:
  - bits 1:0 are 0
  - bits 4:2 are ax[2:0]
  - bits 6:5 are ay[1:0]
  - bit 7 is ax[4]^ay[2]
  - bits 9:8 are B[1:0]
  - bit 10 is ay[3]
  - bit 11 is ax[3]^ay[4]
  - bits 31:12 are B >> 2
- R6: In 16-bit tiled mode the block index is B = (ay/16) × (in_pitch/32) + ax/32, and the address is built as follows:
  - bit 0 is 0
  - bits 3:1 are ax[2:0]
  - bits 6:4 are ay[2:0]
  - bit 7 is ax[3]
  - bits 9:8 are B[1:0]
  - bit 10 is ay[3]
  - bit 11 is ax[4]^ay[4]
  - bits 31:12 are B >> 2
- R7: out_valid equals in_valid delayed by exactly one clock, and the address for a request is on out_addr from the edge that accepts it. Requests on consecutive cycles each produce their own address.
- R8: While rst is high, at the next edge out_valid becomes 0 and out_addr becomes 0.
- R9: An edge with in_valid = 0 leaves out_addr unchanged, whatever the other inputs are.
- R10: in_tile_wide has no effect in linear mode or in 16-bit tiled mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_x | input | 12 | Pixel x inside the window |
| in_y | input | 12 | Pixel y inside the window |
| in_org_x | input | 12 | Window origin x on the surface |
| in_org_y | input | 12 | Window origin y on the surface |
| in_pitch | input | 13 | Surface pitch in pixels |
| in_fmt | input | 1 | Depth word size: 1 = 32-bit, 0 = 16-bit |
| in_linear | input | 1 | 1 = row-major surface, 0 = tiled |
| in_tile_wide | input | 1 | 32-bit tiled only: 1 = 16-pixel blocks, 0 = 8-pixel blocks |
| out_valid | output | 1 | Address on out_addr belongs to a request |
| out_addr | output | 32 | Byte address of the depth word |

## Verification
On every cycle the assertions check the timing contract: the one-cycle valid delay, and that the address holds across idle cycles. On every valid output they also check the fixed parts of each layout: the zero alignment bits of both linear modes, and the positions of the un-swizzled low x and y bits in both tiled layouts. The block index arithmetic, the XOR-folded bits, the choice between 8- and 16-pixel blocks, the origin sums past 4095 and the lack of any effect from the tile select outside 32-bit tiled mode can only be shown by the bench. It compares each address against a reference computed from the coordinate.

// File: rtl/tzaddr_pkg.sv
package tzaddr_pkg;

    localparam int COORD_W = 12;
    localparam int PITCH_W = 13;
    localparam int ADDR_W  = 32;

    typedef enum logic {
        PIX_D16 = 1'b0,
        PIX_D32 = 1'b1
    } pix_fmt_e;

    typedef enum logic {
        TILE_NARROW = 1'b0,
        TILE_WIDE   = 1'b1
    } tile_var_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } addr_rsp_t;

    // log2 of the block edge, per axis, for a given word size and tile variant
    function automatic logic [2:0] blk_shift_x(pix_fmt_e f, tile_var_e t);
        if (f == PIX_D16)         return 3'd5;
        else if (t == TILE_WIDE)  return 3'd4;
        else                      return 3'd3;
    endfunction

    function automatic logic [2:0] blk_shift_y(pix_fmt_e f, tile_var_e t);
        if (f == PIX_D16)         return 3'd4;
        else if (t == TILE_WIDE)  return 3'd4;
        else                      return 3'd3;
    endfunction

endpackage

// File: rtl/tz_origin_add.sv
module tz_origin_add #(
    parameter int CW = 12,
    localparam int SW = CW + 1
) (
    input  logic [CW-1:0] pos_x,
    input  logic [CW-1:0] pos_y,
    input  logic [CW-1:0] org_x,
    input  logic [CW-1:0] org_y,
    output logic [SW-1:0] abs_x,
    output logic [SW-1:0] abs_y
);
    // one extra bit so the window offset never wraps
    always_comb begin
        abs_x = SW'(pos_x) + SW'(org_x);
        abs_y = SW'(pos_y) + SW'(org_y);
    end
endmodule

// File: rtl/tz_linear_map.sv
module tz_linear_map
    import tzaddr_pkg::*;
#(
    parameter int SW = 13,
    parameter int PW = 13,
    parameter int AW = 32
) (
    input  logic [SW-1:0] abs_x,
    input  logic [SW-1:0] abs_y,
    input  logic [PW-1:0] pitch,
    input  pix_fmt_e      fmt,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] pix_index;

    always_comb begin
        pix_index = AW'(abs_x) + AW'(abs_y) * AW'(pitch);
        addr      = (fmt == PIX_D32) ? (pix_index << 2) : (pix_index << 1);
    end
endmodule

// File: rtl/tz_block_index.sv
module tz_block_index
    import tzaddr_pkg::*;
#(
    parameter int SW = 13,
    parameter int PW = 13,
    parameter int BW = 22
) (
    input  logic [SW-1:0] abs_x,
    input  logic [SW-1:0] abs_y,
    input  logic [PW-1:0] pitch,
    input  pix_fmt_e      fmt,
    input  tile_var_e     tvar,
    output logic [BW-1:0] blk
);
    logic [2:0]    sh_x, sh_y;
    logic [BW-1:0] row_blk, row_len, col_blk;

    always_comb begin
        sh_x    = blk_shift_x(fmt, tvar);
        sh_y    = blk_shift_y(fmt, tvar);
        // the pitch is divided by the block width (x edge) of the mode
        row_blk = BW'(abs_y >> sh_y);
        row_len = BW'(pitch >> sh_x);
        col_blk = BW'(abs_x >> sh_x);
        blk     = row_blk * row_len + col_blk;
    end
endmodule

// File: rtl/tz_tile_swizzle.sv
module tz_tile_swizzle #(
    parameter bit WIDE_WORD = 1'b1,
    parameter int AW = 32,
    localparam int BW = AW - 10
) (
    input  logic [4:0]    lo_x,
    input  logic [4:0]    lo_y,
    input  logic [BW-1:0] blk,
    output logic [AW-1:0] addr
);
    generate
        if (WIDE_WORD) begin : g_w32
            // 4-byte words: 8x4 pixel micro-tile below bit 7
            always_comb begin
                addr = {blk[BW-1:2],
                        lo_x[3] ^ lo_y[4],
                        lo_y[3],
                        blk[1:0],
                        lo_x[4] ^ lo_y[2],
                        lo_y[1:0],
                        lo_x[2:0],
                        2'b00};
            end
        end else begin : g_w16
            // 2-byte words: 8x8 pixel micro-tile below bit 7
            always_comb begin
                addr = {blk[BW-1:2],
                        lo_x[4] ^ lo_y[4],
                        lo_y[3],
                        blk[1:0],
                        lo_x[3],
                        lo_y[2:0],
                        lo_x[2:0],
                        1'b0};
            end
        end
    endgenerate
endmodule

// File: rtl/tzaddr_translator.sv
module tzaddr_translator
    import tzaddr_pkg::*;
#(
    parameter int CW = COORD_W,
    parameter int PW = PITCH_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [CW-1:0] in_x,
    input  logic [CW-1:0] in_y,
    input  logic [CW-1:0] in_org_x,
    input  logic [CW-1:0] in_org_y,
    input  logic [PW-1:0] in_pitch,
    input  logic          in_fmt,
    input  logic          in_linear,
    input  logic          in_tile_wide,
    output logic          out_valid,
    output logic [AW-1:0] out_addr
);
    localparam int SW = CW + 1;
    localparam int BW = AW - 10;
    localparam int NLAYOUT = 2;

    pix_fmt_e  fmt;
    tile_var_e tvar;
    logic [SW-1:0] abs_x, abs_y;
    logic [AW-1:0] lin_addr;
    logic [BW-1:0] blk;
    logic [AW-1:0] swz_addr [NLAYOUT];
    logic [AW-1:0] next_addr;
    addr_rsp_t     rsp_q;

    assign fmt  = pix_fmt_e'(in_fmt);
    assign tvar = tile_var_e'(in_tile_wide);

    tz_origin_add #(.CW(CW)) u_org (
        .pos_x(in_x), .pos_y(in_y),
        .org_x(in_org_x), .org_y(in_org_y),
        .abs_x(abs_x), .abs_y(abs_y)
    );

    tz_linear_map #(.SW(SW), .PW(PW), .AW(AW)) u_lin (
        .abs_x(abs_x), .abs_y(abs_y), .pitch(in_pitch),
        .fmt(fmt), .addr(lin_addr)
    );

    tz_block_index #(.SW(SW), .PW(PW), .BW(BW)) u_blk (
        .abs_x(abs_x), .abs_y(abs_y), .pitch(in_pitch),
        .fmt(fmt), .tvar(tvar), .blk(blk)
    );

    // layout 0: 16-bit words, layout 1: 32-bit words
    for (genvar g = 0; g < NLAYOUT; g++) begin : g_layout
        tz_tile_swizzle #(.WIDE_WORD(g == 1), .AW(AW)) u_swz (
            .lo_x(abs_x[4:0]), .lo_y(abs_y[4:0]),
            .blk(blk), .addr(swz_addr[g])
        );
    end

    always_comb begin
        if (in_linear)
            next_addr = lin_addr;
        else if (fmt == PIX_D32)
            next_addr = swz_addr[1];
        else
            next_addr = swz_addr[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= in_valid;
            if (in_valid)
                rsp_q.addr <= next_addr;
        end
    end

    assign out_valid = rsp_q.valid;
    assign out_addr  = rsp_q.addr;

    // R7: output valid is the request valid one edge later
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    // R9: idle edges keep the address
    a_r9_addr_holds: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> $stable(out_addr));

    // R2: linear 32-bit addresses are word aligned
    a_r2_lin32_align: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_linear) && $past(in_fmt)) |-> (out_addr[1:0] == 2'b00));

    // R3: linear 16-bit addresses are halfword aligned
    a_r3_lin16_align: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_linear) && !$past(in_fmt)) |-> (out_addr[0] == 1'b0));

    // R5: plain low bits of the 32-bit tiled layout
    a_r5_tile32_low: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(in_linear) && $past(in_fmt)) |->
        (out_addr[1:0] == 2'b00 && out_addr[4:2] == $past(abs_x[2:0])
         && out_addr[6:5] == $past(abs_y[1:0]) && out_addr[10] == $past(abs_y[3])));

    // R6: plain low bits of the 16-bit tiled layout
    a_r6_tile16_low: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(in_linear) && !$past(in_fmt)) |->
        (out_addr[0] == 1'b0 && out_addr[3:1] == $past(abs_x[2:0])
         && out_addr[6:4] == $past(abs_y[2:0]) && out_addr[7] == $past(abs_x[3])));

endmodule

// File: tb/sim_tzaddr_translator.sv
`timescale 1ns/1ps
module sim_tzaddr_translator;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [11:0] in_x, in_y, in_org_x, in_org_y;
    logic [12:0] in_pitch;
    logic        in_fmt, in_linear, in_tile_wide;
    logic        out_valid;
    logic [31:0] out_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    tzaddr_translator u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_x(in_x), .in_y(in_y), .in_org_x(in_org_x), .in_org_y(in_org_y),
        .in_pitch(in_pitch), .in_fmt(in_fmt), .in_linear(in_linear),
        .in_tile_wide(in_tile_wide), .out_valid(out_valid), .out_addr(out_addr)
    );

    function automatic logic [31:0] ref_addr(
        input int unsigned x, input int unsigned y,
        input int unsigned ox, input int unsigned oy,
        input int unsigned p, input bit w32, input bit lin, input bit wide);
        int unsigned ax, ay, b, a, s;
        ax = x + ox;
        ay = y + oy;
        if (lin) return (w32 ? 4 : 2) * (ax + ay * p);
        a = 0;
        if (w32) begin
            s = wide ? 16 : 8;
            b = (ay / s) * (p / s) + ax / s;
            a |= (ax & 7) << 2;
            a |= (ay & 3) << 5;
            a |= (((ax >> 4) ^ (ay >> 2)) & 1) << 7;
            a |= (((ax >> 3) ^ (ay >> 4)) & 1) << 11;
        end else begin
            b = (ay / 16) * (p / 32) + ax / 32;
            a |= (ax & 7) << 1;
            a |= (ay & 7) << 4;
            a |= ((ax >> 3) & 1) << 7;
            a |= (((ax >> 4) ^ (ay >> 4)) & 1) << 11;
        end
        a |= (b & 3) << 8;
        a |= ((ay >> 3) & 1) << 10;
        a |= (b >> 2) << 12;
        return a;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one request, check its result just after the accepting edge
    task automatic request(input string req, input int unsigned x, input int unsigned y,
                           input int unsigned ox, input int unsigned oy, input int unsigned p,
                           input bit w32, input bit lin, input bit wide);
        @(negedge clk);
        in_valid = 1'b1; in_x = 12'(x); in_y = 12'(y);
        in_org_x = 12'(ox); in_org_y = 12'(oy); in_pitch = 13'(p);
        in_fmt = w32; in_linear = lin; in_tile_wide = wide;
        @(posedge clk); #1;
        check({req, " valid"}, 32'(out_valid), 32'd1);
        check(req, out_addr, ref_addr(x, y, ox, oy, p, w32, lin, wide));
    endtask

    task automatic idle_cycle(input logic [31:0] held);
        @(negedge clk);
        in_valid = 1'b0;
        in_x = 12'($urandom); in_y = 12'($urandom);
        in_linear = 1'($urandom); in_fmt = 1'($urandom);
        @(posedge clk); #1;
        check("R9 hold", out_addr, held);
        check("R7 idle valid", 32'(out_valid), 32'd0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] a_lin, held;
        void'($urandom(32'd1234));
        rst = 1'b1; in_valid = 1'b1;
        in_x = 12'd7; in_y = 12'd9; in_org_x = '0; in_org_y = '0;
        in_pitch = 13'd64; in_fmt = 1'b1; in_linear = 1'b1; in_tile_wide = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset valid", 32'(out_valid), 32'd0);
        check("R8 reset addr", out_addr, 32'd0);
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;

        // R7 latency: nothing before the edge, result right after it
        @(negedge clk);
        in_valid = 1'b1; in_x = 12'd3; in_y = 12'd2; in_pitch = 13'd64;
        in_fmt = 1'b1; in_linear = 1'b1;
        #1;
        check("R7 before edge", 32'(out_valid), 32'd0);
        @(posedge clk); #1;
        check("R7 after edge", out_addr, 32'd4 * (3 + 2 * 64));

        // R2 and R3 linear
        request("R2 lin32", 100, 50, 0, 0, 640, 1'b1, 1'b1, 1'b0);
        request("R3 lin16", 100, 50, 0, 0, 640, 1'b0, 1'b1, 1'b0);
        // R1 origin with sums past 4095
        request("R1 origin lin", 4095, 4095, 4095, 4095, 8160, 1'b1, 1'b1, 1'b0);
        request("R1 origin tiled", 4000, 3000, 1000, 2000, 8160, 1'b1, 1'b0, 1'b1);
        // R4 and R5: both block sizes, corner low bits
        request("R4 narrow", 31, 31, 0, 0, 256, 1'b1, 1'b0, 1'b0);
        request("R4 wide", 31, 31, 0, 0, 256, 1'b1, 1'b0, 1'b1);
        request("R5 xor bit7", 16, 0, 0, 0, 256, 1'b1, 1'b0, 1'b0);
        request("R5 xor bit11", 8, 16, 0, 0, 256, 1'b1, 1'b0, 1'b0);
        // R6 16-bit tiled
        request("R6 tile16", 45, 27, 3, 5, 512, 1'b0, 1'b0, 1'b0);
        request("R6 xor bit11", 16, 0, 0, 0, 512, 1'b0, 1'b0, 1'b0);

        // R10: tile select ignored in linear and 16-bit tiled modes
        request("R10 lin a", 77, 33, 1, 2, 320, 1'b1, 1'b1, 1'b0);
        a_lin = out_addr;
        request("R10 lin b", 77, 33, 1, 2, 320, 1'b1, 1'b1, 1'b1);
        check("R10 lin same", out_addr, a_lin);
        request("R10 t16 a", 77, 33, 1, 2, 320, 1'b0, 1'b0, 1'b0);
        a_lin = out_addr;
        request("R10 t16 b", 77, 33, 1, 2, 320, 1'b0, 1'b0, 1'b1);
        check("R10 t16 same", out_addr, a_lin);

        // R9 hold across idle edges
        held = out_addr;
        idle_cycle(held);
        idle_cycle(held);

        // random back-to-back traffic, R7 with all modes
        for (int i = 0; i < 400; i++) begin
            request("R7 random", $urandom % 4096, $urandom % 4096,
                    $urandom % 4096, $urandom % 4096, ($urandom % 256) * 32,
                    1'($urandom), 1'($urandom), 1'($urandom));
            if ($urandom % 8 == 0) idle_cycle(out_addr);
        end

        // R8 reset mid-stream
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        @(posedge clk); #1;
        check("R8 mid reset valid", 32'(out_valid), 32'd0);
        check("R8 mid reset addr", out_addr, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule